// File: doc/BRIEF.md
# USB Host Frame Timing Unit

This block keeps time for a USB host controller. A down-counter measures the bit times left in the current frame. It advances once per 12 MHz bit-time enable and reloads from a frame-interval parameter when it reaches zero. Each reload is a frame boundary. At a boundary the block steps a frame number and then runs a fixed sequence. First it requests the start-of-frame token from the serializer. Next it requests a write of the new frame number into the shared host memory area. When that write is acknowledged, it sets a start-of-frame status flag. Descriptor fetching is held off until the whole sequence has finished.

The block also gates low-speed traffic for the scheduler. It compares the time left in the frame against an 11-bit commit threshold. A low-speed transaction may start only when at least that much time remains. Software reaches the threshold, the frame number and the status flag through one-cycle command strobes. Reads and writes use separate command codes.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the threshold is 628h, the frame number is 0, the remaining count equals the frame-interval parameter, the status flag is 0, and no request is raised.
- R2: While operational, each cycle with `bitTick` high decrements the remaining count by one. A tick that finds the count at zero reloads it with the frame-interval value instead, and that reload is a frame boundary.
- R3: The frame number increases by exactly one at every frame boundary, wraps from all-ones to zero, and changes at no other time.
- R4: The first cycle in which `operational` is high after being low is also a frame boundary. It increments the frame number, reloads the count and starts the boundary sequence.
- R5: After a boundary, `sofReq` stays high until `sofDone` is seen. Only then is `memWrReq` raised, and it stays high until `memWrDone` is seen. The two requests are never high together.
- R6: While `memWrReq` is high, `memWrData` carries the current frame number.
- R7: The cycle after `memWrDone` is accepted, the status flag reads 1. Command code 84h with data bit 0 set clears the flag. If a set and a clear fall in the same cycle, the set wins. Command code 04h reads the flag in bit 0.
- R8: `descEnable` is high only while operational and no boundary sequence is pending. It is low from the edge after a boundary until the memory-write acknowledge is accepted.
- R9: `lsPermit` is high exactly when operational and the remaining count is greater than or equal to the threshold.
- R10: Command code 91h stores data bits 10:0 as the threshold and ignores bits 31:11. Code 11h reads the threshold back with bits 31:11 as zero.
- R11: Code 0Fh reads the frame number, zero-extended. Code 8Fh and any other code leave all state unchanged, and unknown read codes return zero.
- R12: While not operational, the remaining count holds at the interval value, the frame number holds, and no sequence request is high. A sequence in progress is abandoned when `operational` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| operational | input | 1 | Controller is in the operational state |
| bitTick | input | 1 | One-cycle enable per 12 MHz bit time |
| sofReq | output | 1 | Request to emit the start-of-frame token |
| sofDone | input | 1 | Serializer has issued the token |
| memWrReq | output | 1 | Request to write the frame number to host memory |
| memWrData | output | 16 | Frame number to be written |
| memWrDone | input | 1 | Host-memory write completed |
| descEnable | output | 1 | Descriptor fetching allowed |
| lsPermit | output | 1 | A low-speed transaction may start |
| frameRemaining | output | 14 | Bit times left in the frame |
| frameNumber | output | 16 | Current frame number |
| sofFlag | output | 1 | Start-of-frame status flag |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 8 | Command code |
| cmdWrData | input | 32 | Write data for a command |
| cmdRdData | output | 32 | Read data for the code on `cmdCode` |

## Verification
The assertions assume that `operational` and the command inputs are low while reset is held. They also assume that an acknowledge is only meaningful while its request is high. An acknowledge given at any other time must be ignored, and the sequence checks rely on that. The stimulus drives `sofDone` and `memWrDone` at random, including while no request is pending, to exercise that rule. It also drops `operational` in the middle of a sequence and later raises it again, so both sides of R12 and R4 are reached. Threshold values are spread from zero up past the frame interval, so `lsPermit` sees both outcomes of the comparison.

// File: rtl/usbft_pkg.sv
package usbft_pkg;

  localparam logic [7:0] CODE_THR_RD  = 8'h11;
  localparam logic [7:0] CODE_THR_WR  = 8'h91;
  localparam logic [7:0] CODE_FN_RD   = 8'h0F;
  localparam logic [7:0] CODE_STAT_RD = 8'h04;
  localparam logic [7:0] CODE_STAT_WR = 8'h84;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SOF   = 2'd1,
    SEQ_MEMWR = 2'd2
  } seqState_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic reload;   // load the remaining counter with the interval
    logic count;    // decrement the remaining counter
    logic advance;  // step the frame number
    logic setFlag;  // set the start-of-frame status flag
  } frameStrobes_t;

endpackage

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import usbft_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          operational,
  input  logic          bitTick,
  input  logic          remZero,
  input  logic          sofDone,
  input  logic          memWrDone,
  output frameStrobes_t strobes,
  output logic          sofReq,
  output logic          memWrReq,
  output logic          descEnable
);

  seqState_e state, stateNext;
  logic      prevOp;
  logic      opRise;
  logic      boundary;

  always_comb begin
    opRise   = operational && !prevOp;
    boundary = opRise || (operational && bitTick && remZero);

    strobes.reload  = !operational || boundary;
    strobes.count   = operational && bitTick && !boundary;
    strobes.advance = boundary;
    strobes.setFlag = operational && (state == SEQ_MEMWR) && memWrDone;
  end

  always_comb begin
    stateNext = state;
    if (!operational) begin
      stateNext = SEQ_IDLE;
    end else if (boundary) begin
      stateNext = SEQ_SOF;
    end else begin
      unique case (state)
        SEQ_SOF:   if (sofDone)   stateNext = SEQ_MEMWR;
        SEQ_MEMWR: if (memWrDone) stateNext = SEQ_IDLE;
        default:   stateNext = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= SEQ_IDLE;
      prevOp <= 1'b0;
    end else begin
      state  <= stateNext;
      prevOp <= operational;
    end
  end

  assign sofReq     = (state == SEQ_SOF);
  assign memWrReq   = (state == SEQ_MEMWR);
  assign descEnable = operational && (state == SEQ_IDLE);

  // R5: token request and memory request never overlap
  p_req_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(sofReq && memWrReq));

  // R5: memory write is requested only right after the token was acknowledged
  p_mem_after_sof_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrReq) |-> $past(sofReq && sofDone));

  // R8: descriptors stay blocked while any sequence request is pending
  p_desc_blocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sofReq || memWrReq) |-> !descEnable);

  // R12: dropping out of the operational state abandons the sequence
  p_idle_when_off_r12: assert property (@(posedge clk) disable iff (!rstN)
    !operational |=> !(sofReq || memWrReq));

  // R4: entering the operational state starts a sequence
  p_entry_starts_r4: assert property (@(posedge clk) disable iff (!rstN)
    (operational && !prevOp) |=> sofReq);

endmodule

// File: rtl/frame_timer_dp.sv
module frame_timer_dp
  import usbft_pkg::*;
#(
  parameter int REM_W          = 14,
  parameter int FN_W           = 16,
  parameter int THR_W          = 11,
  parameter int DATA_W         = 32,
  parameter int FRAME_INTERVAL = 11999,
  parameter int THR_RESET      = 'h628
) (
  input  logic              clk,
  input  logic              rstN,
  input  frameStrobes_t     strobes,
  input  logic              operational,
  input  logic              cmdValid,
  input  logic [7:0]        cmdCode,
  input  logic [DATA_W-1:0] cmdWrData,
  output logic              remZero,
  output logic [REM_W-1:0]  frameRemaining,
  output logic [FN_W-1:0]   frameNumber,
  output logic              sofFlag,
  output logic              lsPermit,
  output logic [DATA_W-1:0] cmdRdData
);

  localparam logic [REM_W-1:0] RELOAD   = REM_W'(FRAME_INTERVAL);
  localparam logic [THR_W-1:0] THR_INIT = THR_W'(THR_RESET);
  localparam int               CMP_W    = (REM_W > THR_W) ? REM_W : THR_W;

  logic [REM_W-1:0] remCnt;
  logic [FN_W-1:0]  fnCnt;
  logic [THR_W-1:0] thrReg;
  logic             flagReg;
  logic             thrWrite;
  logic             flagClear;

  assign thrWrite  = cmdValid && (cmdCode == CODE_THR_WR);
  assign flagClear = cmdValid && (cmdCode == CODE_STAT_WR) && cmdWrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remCnt <= RELOAD;
    end else if (strobes.reload) begin
      remCnt <= RELOAD;
    end else if (strobes.count) begin
      remCnt <= remCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fnCnt <= '0;
    end else if (strobes.advance) begin
      fnCnt <= fnCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrReg <= THR_INIT;
    end else if (thrWrite) begin
      thrReg <= cmdWrData[THR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagReg <= 1'b0;
    end else if (strobes.setFlag) begin
      flagReg <= 1'b1;
    end else if (flagClear) begin
      flagReg <= 1'b0;
    end
  end

  always_comb begin
    cmdRdData = '0;
    unique case (cmdCode)
      CODE_THR_RD:  cmdRdData[THR_W-1:0] = thrReg;
      CODE_FN_RD:   cmdRdData[FN_W-1:0]  = fnCnt;
      CODE_STAT_RD: cmdRdData[0]         = flagReg;
      default:      cmdRdData            = '0;
    endcase
  end

  assign remZero        = (remCnt == '0);
  assign frameRemaining = remCnt;
  assign frameNumber    = fnCnt;
  assign sofFlag        = flagReg;
  assign lsPermit       = operational &&
                          (CMP_W'(remCnt) >= CMP_W'(thrReg));

  // R2: the counter never leaves the range of the interval
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameRemaining <= RELOAD);

  // R2: a count strobe lowers the count by one
  p_rem_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.count |=> frameRemaining == REM_W'($past(frameRemaining) - 1'b1));

  // R3: the frame number steps by one on an advance strobe
  p_fn_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> frameNumber == FN_W'($past(frameNumber) + 1'b1));

  // R3: without an advance strobe the frame number holds
  p_fn_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> $stable(frameNumber));

  // R7: an accepted memory acknowledge sets the flag
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setFlag |=> sofFlag);

endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import usbft_pkg::*;
#(
  parameter int REM_W          = 14,
  parameter int FN_W           = 16,
  parameter int THR_W          = 11,
  parameter int DATA_W         = 32,
  parameter int FRAME_INTERVAL = 11999,
  parameter int THR_RESET      = 'h628
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              operational,
  input  logic              bitTick,
  output logic              sofReq,
  input  logic              sofDone,
  output logic              memWrReq,
  output logic [FN_W-1:0]   memWrData,
  input  logic              memWrDone,
  output logic              descEnable,
  output logic              lsPermit,
  output logic [REM_W-1:0]  frameRemaining,
  output logic [FN_W-1:0]   frameNumber,
  output logic              sofFlag,
  input  logic              cmdValid,
  input  logic [7:0]        cmdCode,
  input  logic [DATA_W-1:0] cmdWrData,
  output logic [DATA_W-1:0] cmdRdData
);

  frameStrobes_t strobes;
  logic          remZero;

  frame_seq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .operational(operational),
    .bitTick    (bitTick),
    .remZero    (remZero),
    .sofDone    (sofDone),
    .memWrDone  (memWrDone),
    .strobes    (strobes),
    .sofReq     (sofReq),
    .memWrReq   (memWrReq),
    .descEnable (descEnable)
  );

  frame_timer_dp #(
    .REM_W         (REM_W),
    .FN_W          (FN_W),
    .THR_W         (THR_W),
    .DATA_W        (DATA_W),
    .FRAME_INTERVAL(FRAME_INTERVAL),
    .THR_RESET     (THR_RESET)
  ) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .operational   (operational),
    .cmdValid      (cmdValid),
    .cmdCode       (cmdCode),
    .cmdWrData     (cmdWrData),
    .remZero       (remZero),
    .frameRemaining(frameRemaining),
    .frameNumber   (frameNumber),
    .sofFlag       (sofFlag),
    .lsPermit      (lsPermit),
    .cmdRdData     (cmdRdData)
  );

  assign memWrData = frameNumber;

  // R6: the write data tracks the frame number during a write request
  p_wrdata_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq |-> (memWrData == frameNumber));

endmodule

// File: tb/test_usb_frame_timer.sv
`timescale 1ns/1ps
module test_usb_frame_timer;

  localparam int INTERVAL = 40;
  localparam int LIMIT    = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        operational = 1'b0, bitTick = 1'b0;
  logic        sofDone = 1'b0, memWrDone = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdCode = 8'h00;
  logic [31:0] cmdWrData = '0;
  logic        sofReq, memWrReq, descEnable, lsPermit, sofFlag;
  logic [15:0] memWrData, frameNumber;
  logic [13:0] frameRemaining;
  logic [31:0] cmdRdData;

  // small second instance for the wrap check
  logic        wOp = 1'b0;
  logic        wSofReq, wMemReq, wDesc, wPermit, wFlag;
  logic [3:0]  wWrData, wFn;
  logic [13:0] wRem;
  logic [31:0] wRd;

  int vectors = 0, errors = 0, cycles = 0;
  bit done = 0, modelOn = 0;

  // behavioural reference state
  int mRem, mFn, mThr, mFlag, mPhase, mPrevOp;

  always #2.5 clk = ~clk;

  usb_frame_timer #(.FRAME_INTERVAL(INTERVAL)) i_usb_frame_timer (
    .clk(clk), .rstN(rstN), .operational(operational), .bitTick(bitTick),
    .sofReq(sofReq), .sofDone(sofDone), .memWrReq(memWrReq),
    .memWrData(memWrData), .memWrDone(memWrDone), .descEnable(descEnable),
    .lsPermit(lsPermit), .frameRemaining(frameRemaining),
    .frameNumber(frameNumber), .sofFlag(sofFlag), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .cmdWrData(cmdWrData), .cmdRdData(cmdRdData));

  usb_frame_timer #(.FRAME_INTERVAL(2), .FN_W(4)) i_wrap (
    .clk(clk), .rstN(rstN), .operational(wOp), .bitTick(1'b1),
    .sofReq(wSofReq), .sofDone(1'b1), .memWrReq(wMemReq),
    .memWrData(wWrData), .memWrDone(1'b1), .descEnable(wDesc),
    .lsPermit(wPermit), .frameRemaining(wRem), .frameNumber(wFn),
    .sofFlag(wFlag), .cmdValid(1'b0), .cmdCode(8'h00), .cmdWrData(32'h0),
    .cmdRdData(wRd));

  task automatic check(string req, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
               req, what, act, exp, cycles);
    end
  endtask

  function automatic int expRead(int code);
    case (code)
      8'h11:   return mThr;
      8'h0F:   return mFn;
      8'h04:   return mFlag;
      default: return 0;
    endcase
  endfunction

  // reference model update on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mRem = INTERVAL; mFn = 0; mThr = 'h628; mFlag = 0; mPhase = 0; mPrevOp = 0;
    end else begin
      bit rise, bnd, setF, clr;
      rise = operational && !mPrevOp;
      bnd  = rise || (operational && bitTick && mRem == 0);
      setF = operational && mPhase == 2 && memWrDone;
      clr  = cmdValid && cmdCode == 8'h84 && cmdWrData[0];
      if (setF) mFlag = 1; else if (clr) mFlag = 0;
      if (!operational || bnd) mRem = INTERVAL;
      else if (bitTick) mRem = mRem - 1;
      if (bnd) mFn = (mFn + 1) % 65536;
      if (!operational) mPhase = 0;
      else if (bnd) mPhase = 1;
      else if (mPhase == 1 && sofDone) mPhase = 2;
      else if (mPhase == 2 && memWrDone) mPhase = 0;
      if (cmdValid && cmdCode == 8'h91) mThr = cmdWrData & 32'h7FF;
      mPrevOp = operational;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (modelOn && rstN) begin
      check("R2", "frameRemaining", frameRemaining, mRem);
      check("R3", "frameNumber", frameNumber, mFn);
      check("R5", "sofReq", sofReq, mPhase == 1);
      check("R5", "memWrReq", memWrReq, mPhase == 2);
      if (memWrReq) check("R6", "memWrData", memWrData, mFn);
      check("R7", "sofFlag", sofFlag, mFlag);
      check("R8", "descEnable", descEnable, operational && mPhase == 0);
      check("R9", "lsPermit", lsPermit, operational && mRem >= mThr);
      check("R10/R11", "cmdRdData", cmdRdData, expRead(cmdCode));
    end
    if (cycles > LIMIT && !done) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  // wrap instance: frame number seen on each write request
  int  wExp = 1;
  bit  wrapSeen = 0;
  always @(negedge clk) begin
    if (rstN && wOp && wMemReq) begin
      check("R3", "wrap memWrData", wWrData, wExp);
      if (wWrData == 0) wrapSeen = 1;
      wExp = (wExp + 1) % 16;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic randomInputs(bit allowOp);
    int c;
    bitTick   = ($urandom % 4) != 0;
    sofDone   = ($urandom % 3) == 0;
    memWrDone = ($urandom % 3) == 0;
    cmdValid  = ($urandom % 3) == 0;
    c = $urandom % 8;
    case (c)
      0: cmdCode = 8'h11; 1: cmdCode = 8'h0F; 2: cmdCode = 8'h04;
      3: cmdCode = 8'h91; 4: cmdCode = 8'h84; 5: cmdCode = 8'h8F;
      6: cmdCode = 8'h55; default: cmdCode = 8'h91;
    endcase
    cmdWrData = (cmdCode == 8'h91) ? ($urandom % 64) | ($urandom & 32'hFFFF_F800)
                                   : $urandom;
    if (allowOp && ($urandom % 300) == 0) operational = ~operational;
  endtask

  initial begin
    void'($urandom(32'h1234));
    cyc(4);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, read threshold and frame number through commands
    cmdCode = 8'h11; #1;
    check("R1", "threshold reset", cmdRdData, 32'h628);
    cmdCode = 8'h0F; #1;
    check("R1", "frame number reset", cmdRdData, 0);
    check("R1", "remaining reset", frameRemaining, INTERVAL);
    check("R1", "flag reset", sofFlag, 0);
    check("R1", "requests reset", {sofReq, memWrReq}, 0);
    modelOn = 1;

    // R12: ticks while not operational change nothing
    bitTick = 1'b1;
    cyc(10);
    check("R12", "remaining held", frameRemaining, INTERVAL);
    check("R12", "frame number held", frameNumber, 0);
    check("R12", "no permit", lsPermit, 0);

    // R4: entering operational steps the frame number and requests SOF
    operational = 1'b1; wOp = 1'b1;
    bitTick = 1'b0;
    cyc(1);
    check("R4", "frame number after entry", frameNumber, 1);
    check("R4", "sofReq after entry", sofReq, 1);

    // R5/R7: a clean handshake in order
    sofDone = 1'b1; cyc(1); sofDone = 1'b0;
    check("R5", "memWrReq after token ack", memWrReq, 1);
    memWrDone = 1'b1; cyc(1); memWrDone = 1'b0;
    check("R7", "flag after write ack", sofFlag, 1);
    check("R8", "desc enabled after ack", descEnable, 1);

    // R7: clear by writing one
    cmdValid = 1'b1; cmdCode = 8'h84; cmdWrData = 32'h1;
    cyc(1); cmdValid = 1'b0;
    check("R7", "flag cleared", sofFlag, 0);

    // R10: threshold write ignores upper bits
    cmdValid = 1'b1; cmdCode = 8'h91; cmdWrData = 32'hFFFF_F815;
    cyc(1); cmdValid = 1'b0; cmdCode = 8'h11; #1;
    check("R10", "threshold masked", cmdRdData, 32'h015);

    // R11: writes to the frame number code are ignored
    cmdValid = 1'b1; cmdCode = 8'h8F; cmdWrData = 32'h0000_1234;
    cyc(1); cmdValid = 1'b0;
    check("R11", "frame number unchanged", frameNumber, 1);

    // random traffic with operational toggling
    repeat (6000) begin
      randomInputs(1'b1);
      cyc(1);
    end
    operational = 1'b1;
    repeat (2000) begin
      randomInputs(1'b0);
      cyc(1);
    end

    check("R3", "wrap observed", wrapSeen, 1);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule